// File: doc/BRIEF.md
# Serial Management Command Bridge

This block connects a byte-wide processor bus to the serial management port of a repeater device. The processor writes a one-byte command into a command/reply register. In the clock after the write completes, the block starts shifting that byte out serially, most significant bit first. The shift clock runs at the system clock divided by a parameter. If the command asks for data, the block waits one turnaround bit. It then shifts in an eight-bit answer, which replaces the command in the same register. The processor therefore reads the answer from the place where it wrote the command.

The processor bus has a ready line. A read or a write to either command register while a transfer is in flight drives ready low until the transfer ends, so the processor waits instead of seeing a stale byte. A second command register is meant for write-type commands. The kind of a command is carried in its top bit. A command of the wrong kind written to either register is still sent. It also sets a sticky error bit, which the processor clears by reading the status register.

Top module: `mgmt_cmd_bridge`

## Requirements
- R1: After reset, ready is high when the bus is idle, the shift clock and serial output are low, and both command registers and the status register read as 0.
- R2: With page select 0, register select 31 is the command/reply register and 30 is the write-command register, and both are read/write. Register select 29 is the status register, with the error flag in bit 0 and bits 7..1 reading 0. Any other page or register reads 0 and has no effect.
- R3: The serial transfer begins in the clock after the write that loads a command is accepted. The shift clock stays low during that clock.
- R4: While active, the shift clock is low for the first DIV/2 system clocks of each bit and high for the rest. The command is sent most significant bit first. Each bit is held on the serial output for a whole bit period, and the serial output is low outside the command phase.
- R5: A command with bit 7 = 1 (read-type) is followed by one idle turnaround bit and then eight reply bits. Each reply bit is sampled in the first system clock of the shift-clock high phase, most significant bit first. The reply byte then replaces the contents of register 31.
- R6: A command with bit 7 = 0 (write-type) has no turnaround or reply phase. The transfer ends after eight bits, and register 31 keeps its previous contents (the command itself, if it was written there).
- R7: A read of register 30 or 31 that starts during a transfer holds ready low until the transfer completes. It then returns the updated contents.
- R8: A write to register 30 or 31 during a transfer is stalled until the transfer completes. It is then accepted and starts a new transfer.
- R9: A write-type command (bit 7 = 0) written to register 31 is still sent, and it sets the error flag.
- R10: A read-type command (bit 7 = 1) written to register 30 is still sent, its reply lands in register 31, register 30 keeps the command, and the error flag is set.
- R11: The error flag stays set until a status read. That read returns 1, and the next status read returns 0.
- R12: Reads of the status register and of unmapped addresses never stall, even during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Bus select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_page | input | 5 | Page select |
| bus_reg | input | 5 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while ready is high |
| bus_rdy | output | 1 | Ready; low stalls the current access |
| mg_clk | output | 1 | Serial shift clock |
| mg_out | output | 1 | Serial command output |
| mg_in | input | 1 | Serial reply input |

## Verification
The bench builds the bridge with DIV = 4 and an eight-bit data path. A read-type transfer then lasts 68 system clocks and a write-type transfer 32, so the expected stall lengths are exact numbers that the bench checks directly. With DIV = 4, the reply sample point and the end of a bit period fall in different clocks. The bench's remote device changes its reply bit on each falling shift-clock edge, which exercises the sampling point named in R5. Each cycle, a behavioural countdown model predicts the expected ready, shift clock and serial output and compares them with the design, including during back-to-back and stalled accesses.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_TURN = 2'd2,
    PH_RESP = 2'd3
  } mphase_e;

  // A command of the wrong kind for the register it was written to.
  function automatic logic slot_mismatch(input logic to_reply_slot, input logic cmd_msb);
    return to_reply_slot ? !cmd_msb : cmd_msb;
  endfunction

  // System clocks a transfer occupies once it has started.
  function automatic int unsigned xfer_len(input logic is_read, input int unsigned width,
                                           input int unsigned div);
    return is_read ? (2 * width + 1) * div : width * div;
  endfunction

endpackage

// File: rtl/mgmt_addr_decode.sv
module mgmt_addr_decode #(
  parameter int AW       = 5,
  parameter int PAGE     = 0,
  parameter int GET_IDX  = 31,
  parameter int SET_IDX  = 30,
  parameter int STAT_IDX = 29
) (
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] page,
  input  logic [AW-1:0] rsel,
  input  logic          busy,
  output logic          sel_get,
  output logic          sel_set,
  output logic          sel_stat,
  output logic          rdy,
  output logic          get_wr_acc,
  output logic          set_wr_acc,
  output logic          stat_rd_acc
);

  logic page_hit;
  logic cmd_access;

  assign page_hit = cs && (page == AW'(PAGE));
  assign sel_get  = page_hit && (rsel == AW'(GET_IDX));
  assign sel_set  = page_hit && (rsel == AW'(SET_IDX));
  assign sel_stat = page_hit && (rsel == AW'(STAT_IDX));

  // only the two command registers ever wait on the serial engine
  assign cmd_access = (sel_get || sel_set) && (rd || wr);
  assign rdy        = !(cmd_access && busy);

  assign get_wr_acc  = sel_get && wr && rdy;
  assign set_wr_acc  = sel_set && wr && rdy;
  assign stat_rd_acc = sel_stat && rd && !wr;

endmodule

// File: rtl/mgmt_cmd_regs.sv
module mgmt_cmd_regs
  import mgmt_bridge_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         get_wr_acc,
  input  logic         set_wr_acc,
  input  logic         stat_rd_acc,
  input  logic         sel_get,
  input  logic         sel_set,
  input  logic         sel_stat,
  input  logic [W-1:0] wdata,
  input  logic         reply_valid,
  input  logic [W-1:0] reply_data,
  input  logic         engine_active,
  output logic [W-1:0] rdata,
  output logic         launch,
  output logic [W-1:0] cmd,
  output logic         busy
);

  logic [W-1:0] get_q, set_q;
  logic         err_q;
  logic         raise_err;

  assign raise_err = (get_wr_acc && slot_mismatch(1'b1, wdata[W-1])) ||
                     (set_wr_acc && slot_mismatch(1'b0, wdata[W-1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      get_q  <= '0;
      set_q  <= '0;
      cmd    <= '0;
      launch <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      launch <= get_wr_acc || set_wr_acc;
      if (get_wr_acc) begin
        get_q <= wdata;
        cmd   <= wdata;
      end
      if (set_wr_acc) begin
        set_q <= wdata;
        cmd   <= wdata;
      end
      if (reply_valid) get_q <= reply_data;
      if (raise_err) err_q <= 1'b1;
      else if (stat_rd_acc) err_q <= 1'b0;
    end
  end

  assign busy = launch || engine_active;

  always_comb begin
    rdata = '0;
    if (sel_get) rdata = get_q;
    else if (sel_set) rdata = set_q;
    else if (sel_stat) rdata = {{(W-1){1'b0}}, err_q};
  end

  // R3
  launch_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (get_wr_acc || set_wr_acc) |=> (launch && busy));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !stat_rd_acc) |=> err_q);

  // R5
  reply_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> cmd[W-1]);

endmodule

// File: rtl/mgmt_serial_engine.sv
module mgmt_serial_engine
  import mgmt_bridge_pkg::*;
#(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] cmd,
  input  logic         sin,
  output logic         sclk,
  output logic         sout,
  output logic         active,
  output logic         reply_valid,
  output logic [W-1:0] reply_data
);

  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BIT_W = $clog2(W);
  localparam int HALF  = DIV / 2;
  localparam bit SAMPLE_AT_END = (HALF == DIV - 1);

  mphase_e          phase_q;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [W-1:0]     sh_q;
  logic             is_read_q;
  logic             bit_end;
  logic             sample_now;
  logic             last_bit;

  assign bit_end    = (div_q == DIV_W'(DIV - 1));
  assign sample_now = (phase_q == PH_RESP) && (div_q == DIV_W'(HALF));
  assign last_bit   = (bit_q == BIT_W'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      div_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      is_read_q <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_q   <= PH_CMD;
        sh_q      <= cmd;
        is_read_q <= cmd[W-1];
        div_q     <= '0;
        bit_q     <= '0;
      end
    end else begin
      div_q <= bit_end ? '0 : div_q + 1'b1;
      if (sample_now) sh_q <= {sh_q[W-2:0], sin};
      if (bit_end) begin
        unique case (phase_q)
          PH_CMD: begin
            sh_q <= {sh_q[W-2:0], 1'b0};
            if (last_bit) begin
              bit_q   <= '0;
              phase_q <= is_read_q ? PH_TURN : PH_IDLE;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          PH_TURN: begin
            bit_q   <= '0;
            phase_q <= PH_RESP;
          end
          PH_RESP: begin
            if (last_bit) phase_q <= PH_IDLE;
            else bit_q <= bit_q + 1'b1;
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign active      = (phase_q != PH_IDLE);
  assign sclk        = active && (div_q >= DIV_W'(HALF));
  assign sout        = (phase_q == PH_CMD) && sh_q[W-1];
  assign reply_valid = (phase_q == PH_RESP) && bit_end && last_bit;

  generate
    if (SAMPLE_AT_END) begin : g_late
      assign reply_data = {sh_q[W-2:0], sin};
    end else begin : g_early
      assign reply_data = sh_q;
    end
  endgenerate

  // counter-based length check of one whole transfer
  logic [15:0] run_len_q;
  logic        fin;
  assign fin = active && bit_end &&
               (((phase_q == PH_CMD) && last_bit && !is_read_q) || reply_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len_q <= '0;
    else if (!active) run_len_q <= '0;
    else run_len_q <= run_len_q + 1'b1;
  end

  // R5 R6
  xfer_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (32'(run_len_q) + 1 == xfer_len(is_read_q, W, DIV)));

  // R8
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active) |-> 1'b0);

endmodule

// File: rtl/mgmt_cmd_bridge.sv
module mgmt_cmd_bridge #(
  parameter int W        = 8,
  parameter int AW       = 5,
  parameter int DIV      = 4,
  parameter int PAGE     = 0,
  parameter int GET_IDX  = 31,
  parameter int SET_IDX  = 30,
  parameter int STAT_IDX = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_page,
  input  logic [AW-1:0] bus_reg,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_rdy,
  output logic          mg_clk,
  output logic          mg_out,
  input  logic          mg_in
);

  logic         busy;
  logic         sel_get, sel_set, sel_stat;
  logic         get_wr_acc, set_wr_acc, stat_rd_acc;
  logic         launch;
  logic [W-1:0] cmd;
  logic         engine_active;
  logic         reply_valid;
  logic [W-1:0] reply_data;

  mgmt_addr_decode #(
    .AW(AW), .PAGE(PAGE), .GET_IDX(GET_IDX), .SET_IDX(SET_IDX), .STAT_IDX(STAT_IDX)
  ) u_dec (
    .cs(bus_cs), .rd(bus_rd), .wr(bus_wr), .page(bus_page), .rsel(bus_reg),
    .busy(busy), .sel_get(sel_get), .sel_set(sel_set), .sel_stat(sel_stat),
    .rdy(bus_rdy), .get_wr_acc(get_wr_acc), .set_wr_acc(set_wr_acc),
    .stat_rd_acc(stat_rd_acc)
  );

  mgmt_cmd_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .get_wr_acc(get_wr_acc), .set_wr_acc(set_wr_acc),
    .stat_rd_acc(stat_rd_acc), .sel_get(sel_get), .sel_set(sel_set),
    .sel_stat(sel_stat), .wdata(bus_wdata), .reply_valid(reply_valid),
    .reply_data(reply_data), .engine_active(engine_active), .rdata(bus_rdata),
    .launch(launch), .cmd(cmd), .busy(busy)
  );

  mgmt_serial_engine #(.W(W), .DIV(DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(launch), .cmd(cmd), .sin(mg_in),
    .sclk(mg_clk), .sout(mg_out), .active(engine_active),
    .reply_valid(reply_valid), .reply_data(reply_data)
  );

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mg_clk && !mg_out));

  // R3
  launch_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !engine_active) |-> !mg_clk);

endmodule

// File: tb/sim_mgmt_cmd_bridge.sv
`timescale 1ns/1ps
module sim_mgmt_cmd_bridge;
  localparam int DIV = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic b_cs = 0, b_rd = 0, b_wr = 0;
  logic [4:0] b_page = 0, b_reg = 0;
  logic [7:0] b_wd = 0;
  logic [7:0] b_rdata;
  logic b_rdy, s_clk, s_out;
  logic s_in = 0;

  int total = 0, bad = 0;
  int busy_left = 0;
  logic [7:0] m_cmd = 0;
  logic [7:0] reply_byte = 0;
  logic [7:0] rx_cmd = 0;
  int rise_n = 0, fall_n = 0;
  logic prev_sclk = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mgmt_cmd_bridge #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(b_cs), .bus_rd(b_rd), .bus_wr(b_wr),
    .bus_page(b_page), .bus_reg(b_reg), .bus_wdata(b_wd), .bus_rdata(b_rdata),
    .bus_rdy(b_rdy), .mg_clk(s_clk), .mg_out(s_out), .mg_in(s_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit cmd_slot(input logic [4:0] pg, input logic [4:0] rs);
    return (pg == 0) && (rs == 31 || rs == 30);
  endfunction

  function automatic bit exp_rdy();
    return !(b_cs && (b_rd || b_wr) && cmd_slot(b_page, b_reg) && busy_left > 0);
  endfunction

  // reference model: one countdown per transfer
  always @(posedge clk) begin
    bit acc;
    if (rst_n) begin
      acc = exp_rdy();
      if (busy_left > 0) begin
        busy_left--;
      end
      if (b_cs && acc && b_wr && cmd_slot(b_page, b_reg)) begin
        m_cmd = b_wd;
        busy_left = 1 + (b_wd[7] ? 17 : 8) * DIV;
        rise_n = 0;
        fall_n = 0;
        rx_cmd = 0;
        s_in = 0;
      end
    end
  end

  // per-cycle comparison and remote device
  always @(negedge clk) begin
    int tot_len, t;
    bit e_clk, e_out;
    if (rst_n) begin
      cyc++;
      tot_len = (m_cmd[7] ? 17 : 8) * DIV;
      e_clk = 0;
      e_out = 0;
      if (busy_left > 0 && busy_left <= tot_len) begin
        t = tot_len - busy_left;
        e_clk = (t % DIV) >= DIV / 2;
        if (t < 8 * DIV) e_out = m_cmd[7 - t / DIV];
      end
      chk(b_rdy == exp_rdy(), "R7 R8 ready", b_rdy, exp_rdy());
      chk(s_clk == e_clk, "R3 R4 shift clock", s_clk, e_clk);
      chk(s_out == e_out, "R4 serial out", s_out, e_out);
      if (s_clk && !prev_sclk) begin
        rise_n++;
        if (rise_n <= 8) rx_cmd = {rx_cmd[6:0], s_out};
      end
      if (!s_clk && prev_sclk) begin
        fall_n++;
        if (fall_n >= 9 && fall_n <= 16) s_in = reply_byte[16 - fall_n];
      end
      prev_sclk = s_clk;
    end
  end

  task automatic bus_op(input bit is_wr, input logic [4:0] pg, input logic [4:0] rs,
                        input logic [7:0] d, output logic [7:0] q, output int waits);
    @(posedge clk); #1;
    b_cs = 1; b_wr = is_wr; b_rd = !is_wr; b_page = pg; b_reg = rs; b_wd = d;
    waits = 0;
    forever begin
      @(negedge clk);
      if (b_rdy) begin
        q = b_rdata;
        break;
      end
      waits++;
    end
    @(posedge clk); #1;
    b_cs = 0; b_wr = 0; b_rd = 0;
  endtask

  task automatic rd_chk(input logic [4:0] pg, input logic [4:0] rs, input int exp,
                        input string req);
    logic [7:0] q;
    int w;
    bus_op(0, pg, rs, 8'h00, q, w);
    chk(q == exp, req, q, exp);
  endtask

  task automatic wait_idle();
    while (busy_left > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] q;
    int w;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(b_rdy == 1, "R1 ready", b_rdy, 1);
    chk(s_clk == 0 && s_out == 0, "R1 serial idle", {s_clk, s_out}, 0);
    rd_chk(0, 31, 8'h00, "R1 reply reg");
    rd_chk(0, 30, 8'h00, "R1 set reg");
    rd_chk(0, 29, 8'h00, "R1 status");

    // read-type command, reply replaces it
    reply_byte = 8'h3C;
    bus_op(1, 0, 31, 8'hA5, q, w);
    chk(w == 0, "R2 idle write no stall", w, 0);
    wait_idle();
    chk(rx_cmd == 8'hA5, "R4 command bits", rx_cmd, 8'hA5);
    rd_chk(0, 31, 8'h3C, "R5 reply stored");
    rd_chk(0, 29, 8'h00, "R9 no error");

    // early read stalls for the whole transfer
    reply_byte = 8'h5A;
    bus_op(1, 0, 31, 8'h81, q, w);
    bus_op(0, 0, 31, 8'h00, q, w);
    chk(w == 17 * DIV, "R7 read stall cycles", w, 17 * DIV);
    chk(q == 8'h5A, "R7 read returns reply", q, 8'h5A);

    // write-type command in its own register, no reply
    bus_op(1, 0, 30, 8'h12, q, w);
    bus_op(0, 0, 30, 8'h00, q, w);
    chk(w == 8 * DIV, "R6 short transfer stall", w, 8 * DIV);
    chk(q == 8'h12, "R2 set reg readback", q, 8'h12);
    rd_chk(0, 31, 8'h5A, "R6 reply reg untouched");
    rd_chk(0, 29, 8'h00, "R10 no error");

    // write-type command in the reply register
    bus_op(1, 0, 31, 8'h34, q, w);
    wait_idle();
    chk(rx_cmd == 8'h34, "R9 still forwarded", rx_cmd, 8'h34);
    rd_chk(0, 31, 8'h34, "R6 keeps command");
    rd_chk(0, 29, 8'h01, "R9 error set");
    rd_chk(0, 29, 8'h00, "R11 cleared by read");

    // read-type command in the write register
    reply_byte = 8'h99;
    bus_op(1, 0, 30, 8'hC3, q, w);
    wait_idle();
    chk(rx_cmd == 8'hC3, "R10 forwarded", rx_cmd, 8'hC3);
    rd_chk(0, 31, 8'h99, "R10 reply in reply reg");
    rd_chk(0, 30, 8'hC3, "R10 set reg keeps command");
    reply_byte = 8'h44;
    bus_op(1, 0, 31, 8'h90, q, w);
    wait_idle();
    rd_chk(0, 29, 8'h01, "R11 sticky across clean transfer");
    rd_chk(0, 29, 8'h00, "R11 cleared");

    // write during transfer, plus non-stalling reads
    reply_byte = 8'h11;
    bus_op(1, 0, 31, 8'h80, q, w);
    bus_op(0, 0, 29, 8'h00, q, w);
    chk(w == 0, "R12 status read no stall", w, 0);
    bus_op(0, 1, 31, 8'h00, q, w);
    chk(w == 0 && q == 0, "R12 unmapped read", {w[7:0], q}, 0);
    bus_op(1, 1, 30, 8'hEE, q, w);
    chk(w == 0, "R2 unmapped write no stall", w, 0);
    bus_op(1, 0, 30, 8'h05, q, w);
    chk(w > 0 && w < 17 * DIV, "R8 write stalled", w, 17 * DIV);
    wait_idle();
    chk(rx_cmd == 8'h05, "R8 queued command sent", rx_cmd, 8'h05);
    rd_chk(0, 31, 8'h11, "R8 first reply kept");
    rd_chk(0, 30, 8'h05, "R2 unmapped write no effect");
    rd_chk(1, 31, 8'h00, "R2 other page reads zero");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule